// File: doc/BRIEF.md
# Zero-turnaround pipelined burst SRAM

This block is a synchronous single-port memory with a shared data path that takes a new command on every enabled clock edge: read, write or deselect. A write carries its data two enabled edges after its address, which is the same distance at which read data comes back. The bus direction can therefore flip between any two cycles without an idle slot, and the data bus stays fully used.

Each command is either a load or an advance. A load takes a fresh external address, the chip-select inputs and the write strobe. An advance steps an internal 2-bit counter through a burst of four words inside the group of four addressed by the load. The burst order is linear or interleaved, chosen at the load. Lanes of each word can be written one at a time. An active-low clock enable freezes the whole pipeline. The output enable gates only the data drive. The data bus appears as separate write-data, read-data and drive-enable signals.

Top module: `nowait_burst_sram`

## Requirements
- R1: After a synchronous reset, `rdata_drive` is low and no command is in flight; a read loaded just before reset never drives the bus.
- R2: A selected read loaded at enabled edge k puts the word on `rdata`, with `rdata_drive` high (if `out_en_n` is low), right after enabled edge k+2.
- R3: A write loaded at enabled edge k takes `wdata` at enabled edge k+2. Lane g is bits [9g+8:9g] and is written only if `byte_wr_n[g]` was 0 at edge k. Lanes not written keep their old contents.
- R4: At an edge where `clk_en_n` is 1, every input is ignored, including `wdata`. No register changes, so `rdata` and the pipeline hold and each pending command moves one edge later.
- R5: With `burst_ilv` = 0 at the load, the beats of a burst use word offsets (s+n) mod 4 for n = 0..3, where s is `addr[1:0]`; `addr` bits above bit 1 stay at their loaded value.
- R6: With `burst_ilv` = 1 at the load, the beats use offsets s XOR n; the upper address bits stay fixed.
- R7: At an advance edge (`advance` = 1) the command repeats the kind of the last load (read, write or deselect). `wr_n`, the chip selects and `addr` are ignored; `byte_wr_n` is taken per beat.
- R8: A load selects the device only when `sel_a_n` = 0, `sel_b` = 1 and `sel_c_n` = 0. Any other pattern is a deselect: nothing is written and the bus is not driven two edges later.
- R9: Reads and writes can alternate on consecutive edges with no idle command between them. Each still keeps its two-edge latency.
- R10: `rdata_drive` is high only while read data is valid and `out_en_n` is 0, and `out_en_n` acts without a clock. After the data edge of a write or a deselect, `rdata_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; 1 freezes the block |
| advance | input | 1 | 0 = load new command, 1 = next burst beat |
| wr_n | input | 1 | 0 = write, 1 = read, taken at a load |
| byte_wr_n | input | LANES | Active-low lane write enables |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_ilv | input | 1 | Burst order at a load: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| addr | input | AW | Word address |
| wdata | input | DW | Write data, taken two enabled edges after its command |
| rdata | output | DW | Read data register |
| rdata_drive | output | 1 | High when the block would drive the data bus |

## Verification
The bench builds the block with the defaults: 16 words, so there are two address bits above the burst offset, and two 9-bit lanes. With 16 words, a burst that wraps past offset 3 shows whether the upper bits stay put, and whether the linear and interleaved orders differ from a start offset of 1 or 3. With two lanes, a write that changes one lane while the other keeps a known pattern is visible in a later read.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Word offset inside a group of four for burst step cnt from start s.
    function automatic logic [1:0] burst_offset(input logic [1:0] s,
                                                input logic [1:0] cnt,
                                                input logic       ilv);
        return ilv ? (s ^ cnt) : (s + cnt);
    endfunction

    // Selected only for the single qualifying chip-select pattern.
    function automatic logic chip_selected(input logic a_n,
                                           input logic b,
                                           input logic c_n);
        return !a_n && b && !c_n;
    endfunction

endpackage

// File: rtl/nbs_burst_seq.sv
module nbs_burst_seq
    import nbs_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic             wr_n,
    input  logic             sel,
    input  logic             ilv,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] byte_wr_n,
    output op_e              op_s1,
    output logic [AW-1:0]    addr_s1,
    output logic [LANES-1:0] lane_s1
);
    localparam int HW = AW - 2;

    logic [HW-1:0] hi_q;
    logic [1:0]    start_q;
    logic [1:0]    cnt_q;
    logic          ilv_q;
    op_e           kind_q;
    op_e           new_op;
    logic [1:0]    cnt_nx;

    always_comb begin
        if (!sel)      new_op = OP_IDLE;
        else if (wr_n) new_op = OP_READ;
        else           new_op = OP_WRITE;
        cnt_nx = cnt_q + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            ilv_q   <= 1'b0;
            kind_q  <= OP_IDLE;
            op_s1   <= OP_IDLE;
            addr_s1 <= '0;
            lane_s1 <= '0;
        end else if (en) begin
            lane_s1 <= ~byte_wr_n;
            if (load) begin
                hi_q    <= addr[AW-1:2];
                start_q <= addr[1:0];
                cnt_q   <= 2'd0;
                ilv_q   <= ilv;
                kind_q  <= new_op;
                op_s1   <= new_op;
                addr_s1 <= addr;
            end else begin
                cnt_q   <= cnt_nx;
                op_s1   <= kind_q;
                addr_s1 <= {hi_q, burst_offset(start_q, cnt_nx, ilv_q)};
            end
        end
    end

endmodule

// File: rtl/nbs_store.sv
module nbs_store #(
    parameter int DEPTH  = 16,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [LANES-1:0]          lane_en,
    input  logic [$clog2(DEPTH)-1:0]  waddr,
    input  logic [LANE_W*LANES-1:0]   wword,
    input  logic [$clog2(DEPTH)-1:0]  raddr,
    output logic [LANE_W*LANES-1:0]   rword
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g])
                bank[waddr] <= wword[g*LANE_W +: LANE_W];
        end

        assign rword[g*LANE_W +: LANE_W] = bank[raddr];
    end

endmodule

// File: rtl/nbs_data_pipe.sv
module nbs_data_pipe
    import nbs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  op_e                       op_s1,
    input  logic [$clog2(DEPTH)-1:0]  addr_s1,
    input  logic [LANES-1:0]          lane_s1,
    input  logic [LANE_W*LANES-1:0]   wdata,
    output logic [LANE_W*LANES-1:0]   rdata_q,
    output logic                      rvalid_q
);
    localparam int AW = $clog2(DEPTH);
    localparam int DW = LANE_W * LANES;

    op_e             op_s2;
    logic [AW-1:0]   addr_s2;
    logic [LANES-1:0] lane_s2;
    logic [DW-1:0]   rword;

    nbs_store #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES)) u_store (
        .clk     (clk),
        .we      (en && (op_s2 == OP_WRITE)),
        .lane_en (lane_s2),
        .waddr   (addr_s2),
        .wword   (wdata),
        .raddr   (addr_s2),
        .rword   (rword)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_s2    <= OP_IDLE;
            addr_s2  <= '0;
            lane_s2  <= '0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (en) begin
            op_s2    <= op_s1;
            addr_s2  <= addr_s1;
            lane_s2  <= lane_s1;
            rvalid_q <= (op_s2 == OP_READ);
            if (op_s2 == OP_READ)
                rdata_q <= rword;
        end
    end

endmodule

// File: rtl/nowait_burst_sram.sv
module nowait_burst_sram
    import nbs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en_n,
    input  logic             advance,
    input  logic             wr_n,
    input  logic [LANES-1:0] byte_wr_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             burst_ilv,
    input  logic             out_en_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rdata_drive
);
    logic             en;
    op_e              op_s1;
    logic [AW-1:0]    addr_s1;
    logic [LANES-1:0] lane_s1;
    logic             rvalid;

    assign en = !clk_en_n;

    nbs_burst_seq #(.AW(AW), .LANES(LANES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .load      (!advance),
        .wr_n      (wr_n),
        .sel       (chip_selected(sel_a_n, sel_b, sel_c_n)),
        .ilv       (burst_ilv),
        .addr      (addr),
        .byte_wr_n (byte_wr_n),
        .op_s1     (op_s1),
        .addr_s1   (addr_s1),
        .lane_s1   (lane_s1)
    );

    nbs_data_pipe #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .op_s1    (op_s1),
        .addr_s1  (addr_s1),
        .lane_s1  (lane_s1),
        .wdata    (wdata),
        .rdata_q  (rdata),
        .rvalid_q (rvalid)
    );

    assign rdata_drive = rvalid && !out_en_n;

endmodule

// File: rtl/nbs_checker.sv
module nbs_checker
    import nbs_pkg::*;
#(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          clk_en_n,
    input logic          advance,
    input logic          wr_n,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          sel_c_n,
    input logic          out_en_n,
    input logic [DW-1:0] rdata,
    input logic          rdata_drive
);
    logic sel;
    assign sel = chip_selected(sel_a_n, sel_b, sel_c_n);

    // R1: the cycle after reset the bus is quiet
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rdata_drive);

    // R2: selected read drives after two more enabled edges
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (!advance && sel && wr_n && !clk_en_n) ##1 !clk_en_n ##1 !clk_en_n
        |=> (rdata_drive == !out_en_n));

    // R4: a frozen edge leaves the read register untouched
    assert_freeze_holds_R4: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> $stable(rdata));

    // R8: deselect load never drives the bus
    assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!advance && !sel && !clk_en_n) ##1 !clk_en_n ##1 !clk_en_n
        |=> !rdata_drive);

    // R10: write data cycle does not drive the bus
    assert_write_no_drive_R10: assert property (@(posedge clk) disable iff (rst)
        (!advance && sel && !wr_n && !clk_en_n) ##1 !clk_en_n ##1 !clk_en_n
        |=> !rdata_drive);

endmodule

bind nowait_burst_sram nbs_checker #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clk_en_n    (clk_en_n),
    .advance     (advance),
    .wr_n        (wr_n),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .out_en_n    (out_en_n),
    .rdata       (rdata),
    .rdata_drive (rdata_drive)
);

// File: tb/nowait_burst_sram_bench.sv
`timescale 1ns/1ps
module nowait_burst_sram_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en_n = 1'b0;
    logic        advance = 1'b0;
    logic        wr_n = 1'b1;
    logic [1:0]  byte_wr_n = 2'b11;
    logic        sel_a_n = 1'b1;
    logic        sel_b = 1'b1;
    logic        sel_c_n = 1'b0;
    logic        burst_ilv = 1'b0;
    logic        out_en_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [17:0] wdata = '0;
    logic [17:0] rdata;
    logic        rdata_drive;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nowait_burst_sram u_nowait_burst_sram (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .advance(advance),
        .wr_n(wr_n), .byte_wr_n(byte_wr_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .burst_ilv(burst_ilv), .out_en_n(out_en_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
    );

    typedef struct packed {
        logic        ce_n;
        logic        adv;
        logic        we_n;
        logic [1:0]  bw_n;
        logic [2:0]  cs;     // {sel_a_n, sel_b, sel_c_n}
        logic        ilv;
        logic        oe_n;
        logic [3:0]  a;
        logic [17:0] wd;
        logic        chk;
        logic        xdrv;
        logic [17:0] xdat;
        logic [3:0]  req;
    } vec_t;

    localparam logic [2:0] S = 3'b010;
    localparam logic [2:0] D = 3'b110;
    localparam int NV = 32;

    // Expected values are the port state right after each vector's edge.
    localparam vec_t VECS [NV] = '{
        '{0,0,0,2'b00,S,0,0,4'd0,18'h00000,0,0,18'h0,4'd0},
        '{0,0,0,2'b00,S,0,0,4'd1,18'h00000,0,0,18'h0,4'd0},
        '{0,0,0,2'b00,S,0,0,4'd2,18'h12345,0,0,18'h0,4'd0},
        '{0,0,0,2'b00,S,0,0,4'd3,18'h2A5A5,0,0,18'h0,4'd0},
        '{0,0,1,2'b00,S,0,0,4'd0,18'h3C3C3,0,0,18'h0,4'd0},
        '{0,0,0,2'b10,S,0,0,4'd0,18'h0F0F0,0,0,18'h0,4'd0},
        '{0,0,1,2'b00,S,0,0,4'd1,18'h00000,1,1,18'h12345,4'd2},  // R2
        '{0,0,1,2'b00,S,0,0,4'd0,18'h3FFFF,1,0,18'h0,4'd10},     // R10 write slot
        '{0,0,1,2'b00,D,0,0,4'd0,18'h00000,1,1,18'h2A5A5,4'd9},  // R9
        '{0,0,1,2'b00,S,0,0,4'd3,18'h00000,1,1,18'h123FF,4'd3},  // R3 lane merge
        '{0,0,1,2'b00,S,0,0,4'd2,18'h00000,1,0,18'h0,4'd8},      // R8
        '{1,0,0,2'b00,S,0,0,4'd1,18'h3FFFF,1,0,18'h0,4'd4},      // R4 frozen
        '{0,0,1,2'b00,D,0,0,4'd0,18'h00000,1,1,18'h0F0F0,4'd4},
        '{0,0,1,2'b00,S,0,0,4'd1,18'h00000,1,1,18'h3C3C3,4'd4},
        '{0,0,1,2'b00,D,0,0,4'd0,18'h00000,1,0,18'h0,4'd8},
        '{0,0,1,2'b00,D,0,0,4'd0,18'h00000,1,1,18'h2A5A5,4'd4},
        '{0,0,0,2'b00,S,0,0,4'd5,18'h00000,0,0,18'h0,4'd0},
        '{0,1,1,2'b00,D,0,0,4'd0,18'h00000,0,0,18'h0,4'd0},
        '{0,1,1,2'b00,D,0,0,4'd0,18'h00555,0,0,18'h0,4'd0},
        '{0,1,1,2'b00,D,0,0,4'd0,18'h00666,0,0,18'h0,4'd0},
        '{0,0,1,2'b00,S,1,0,4'd5,18'h00777,0,0,18'h0,4'd0},
        '{0,1,0,2'b00,D,0,0,4'd0,18'h00444,0,0,18'h0,4'd0},
        '{0,1,0,2'b00,D,0,0,4'd0,18'h00000,1,1,18'h00555,4'd6}, // R6 / R7
        '{0,1,0,2'b00,D,0,0,4'd0,18'h00000,1,1,18'h00444,4'd6},
        '{0,0,1,2'b00,S,0,0,4'd7,18'h00000,1,1,18'h00777,4'd6},
        '{0,1,0,2'b00,D,1,0,4'd0,18'h00000,1,1,18'h00666,4'd6},
        '{0,1,0,2'b00,D,1,0,4'd0,18'h00000,1,1,18'h00777,4'd5}, // R5
        '{0,1,0,2'b00,D,1,0,4'd0,18'h00000,1,1,18'h00444,4'd5},
        '{0,0,1,2'b00,D,0,0,4'd0,18'h00000,1,1,18'h00555,4'd5},
        '{0,1,0,2'b00,S,0,0,4'd0,18'h00000,1,1,18'h00666,4'd5},
        '{0,0,1,2'b00,D,0,0,4'd0,18'h00000,1,0,18'h0,4'd8},
        '{0,0,1,2'b00,D,0,0,4'd0,18'h00000,1,0,18'h0,4'd7}      // R7 deselect burst
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Apply at a falling edge, return after the following rising edge.
    task automatic drive(input vec_t v);
        clk_en_n  = v.ce_n;
        advance   = v.adv;
        wr_n      = v.we_n;
        byte_wr_n = v.bw_n;
        {sel_a_n, sel_b, sel_c_n} = v.cs;
        burst_ilv = v.ilv;
        out_en_n  = v.oe_n;
        addr      = v.a;
        wdata     = v.wd;
        @(negedge clk);
    endtask

    task automatic check(input logic xdrv, input logic [17:0] xdat, input string req);
        n_chk++;
        if (rdata_drive !== xdrv || (xdrv && rdata !== xdat)) begin
            n_bad++;
            $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                     req, rdata_drive, rdata, xdrv, xdat);
        end
    endtask

    function automatic vec_t cmd(input logic adv, input logic we_n,
                                 input logic [2:0] cs, input logic [3:0] a,
                                 input logic [17:0] wd);
        vec_t v = '0;
        v.adv = adv; v.we_n = we_n; v.cs = cs; v.a = a; v.wd = wd;
        return v;
    endfunction

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: drive=%0b data=%h expected drive=0 data=0", rdata_drive, rdata);
        finish_run();
    end

    initial begin
        drive(cmd(0, 1, D, 0, 0));
        drive(cmd(0, 1, D, 0, 0));
        rst = 1'b0;
        drive(cmd(0, 1, D, 0, 0));
        check(1'b0, 18'h0, "R1");

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            if (VECS[i].chk)
                check(VECS[i].xdrv, VECS[i].xdat, $sformatf("R%0d", VECS[i].req));
        end

        // R10: output enable gates the drive without a clock
        begin
            vec_t v = cmd(0, 1, S, 4'd0, 0);
            v.oe_n = 1'b1;
            drive(v);
            v = cmd(0, 1, D, 0, 0); v.oe_n = 1'b1;
            drive(v);
            drive(v);
            check(1'b0, 18'h0, "R10");
            out_en_n = 1'b0;
            #1;
            check(1'b1, 18'h123FF, "R10");
        end

        // R8: only one chip-select pattern selects
        drive(cmd(0, 0, S, 4'd8, 0));
        drive(cmd(0, 1, D, 0, 0));
        drive(cmd(0, 1, D, 0, 18'h1ABCD));
        for (int p = 0; p < 8; p++) begin
            if (p != 2) begin
                drive(cmd(0, 0, 3'(p), 4'd8, 0));
                drive(cmd(0, 1, 3'(p), 4'd8, 0));
                drive(cmd(0, 1, D, 0, 18'h00000));
                check(1'b0, 18'h0, "R8");
            end
        end
        drive(cmd(0, 1, S, 4'd8, 0));
        drive(cmd(0, 1, D, 0, 0));
        drive(cmd(0, 1, D, 0, 0));
        check(1'b1, 18'h1ABCD, "R8");

        // R1: reset clears a read in flight
        drive(cmd(0, 1, S, 4'd0, 0));
        rst = 1'b1;
        drive(cmd(0, 1, D, 0, 0));
        rst = 1'b0;
        drive(cmd(0, 1, D, 0, 0));
        check(1'b0, 18'h0, "R1");
        drive(cmd(0, 1, D, 0, 0));
        check(1'b0, 18'h0, "R1");

        finish_run();
    end

endmodule